// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is the device-side command engine of a parallel NOR flash, with a small flop-based array standing in for the storage. Each cycle with `wr_en` high is one bus write: an address and data pair. The engine decodes these writes as unlock handshakes, program and erase commands, a shortened unlock-bypass mode, suspend and resume of a running operation, and a query read mode. A plain down-counter takes the place of the embedded program and erase algorithms. While an operation runs, or after one has failed, reads return a status word and not array data.

Reads are combinational. `rdata` follows `addr` in the same cycle, and `rd_en` only marks a read for the toggle bit. Command cycles compare the low eight data bits and ignore the upper byte. The full address bus is compared against the unlock addresses. Word address bits below the array size select a word. The upper bits of that field select a block of `BLK_WORDS` words. A program can only clear bits, so the stored word becomes the old value ANDed with the new data.

Top module: `nor_cmd_core`

## Requirements
- R1: After reset `busy` is low, the engine is in read mode, and every word reads as all ones (FFFFh).
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then (address, data) start a program. `busy` is high for exactly `BUSY_CYC` cycles after the edge that takes the fourth write. After that the word holds old AND data.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 10h@555h erase the whole array. If the last write is instead 30h at any address, only the block holding that address is erased. Other blocks are unchanged.
- R4: A command write that does not match the expected step returns the engine to read mode. So does F0h in the middle of a sequence. The interrupted command has no effect.
- R5: The writes AAh@555h, 55h@2AAh, 20h@555h enter bypass mode. In this mode A0h then (address, data) programs a word, 80h then 10h erases the chip, and 80h then 30h@address erases a block. These writes may use any address. The engine stays in bypass mode when the operation ends.
- R6: F0h does not leave bypass mode. Only 90h followed by 00h returns to read mode.
- R7: An FFh command byte on any command step, in read or bypass mode, enters a lost state. There, reads return 0000h and every write except F0h is ignored. F0h returns to read mode with bypass mode cleared.
- R8: A program that would turn a 0 bit to 1 ends in a failed state. The word still holds old AND data. Reads return status with bit 5 set until F0h is written.
- R9: The status word has bits 15..8 and 4..0 at zero. Bit 7 is the inverse of bit 7 of the program data, or 0 for an erase. Bit 6 starts at 0 when an operation begins and flips after each read in the busy or failed state. Bit 5 is set only in the failed state.
- R10: B0h written while busy suspends the operation. `busy` drops, the counter holds, and reads return array contents that the operation has not yet touched. Only 30h resumes, and the remaining count is kept.
- R11: 98h@055h from read mode enters query mode. Reads then return 0051h, 0052h and 0059h at word addresses 10h, 11h and 12h, and 0000h elsewhere. F0h returns to read mode.
- R12: While busy, every write other than B0h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| rd_en | input | 1 | Marks a read, which advances the status toggle bit |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; command byte in bits 7..0 |
| rdata | output | DATA_W | Array word, status word, query word or 0000h, by state |
| busy | output | 1 | An operation is running and not suspended |

## Verification
The bench builds the block with `BUSY_CYC` at 6, four blocks of sixteen words and an 11-bit address. A short busy window lets a status read, a suspend and a stray write all fall inside a running operation. The small array puts a block boundary within easy reach, so one test can show a block erase leaving the neighbouring block intact. The same array size lets a chip erase be confirmed word by word against the reference model.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PGM,
    S_ERS1, S_ERS2, S_ERS3, S_BYP,
    S_BYP_PGM, S_BYP_ERS, S_BYP_RST, S_BUSY,
    S_SUSP, S_FAIL, S_QRY, S_LOST
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_BLOCK = 2'd1,
    OP_CHIP  = 2'd2
  } op_kind_e;

  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_UNLK_A = 8'hAA;
  localparam logic [7:0] C_UNLK_B = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_BLOCK  = 8'h30;
  localparam logic [7:0] C_BYPASS = 8'h20;
  localparam logic [7:0] C_BYP_X1 = 8'h90;
  localparam logic [7:0] C_BYP_X2 = 8'h00;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
  localparam logic [7:0] C_QUERY  = 8'h98;
  localparam logic [7:0] C_BAD    = 8'hFF;

  localparam logic [10:0] A_UNL1 = 11'h555;
  localparam logic [10:0] A_UNL2 = 11'h2AA;
  localparam logic [10:0] A_QRY  = 11'h055;

  function automatic logic [15:0] query_word(input logic [7:0] off);
    case (off)
      8'h10:   query_word = 16'h0051;
      8'h11:   query_word = 16'h0052;
      8'h12:   query_word = 16'h0059;
      default: query_word = 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_n  = CW'(BUSY_CYC);
    end else if (run && cnt_q > CW'(1)) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(BUSY_CYC);
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign done = run && (cnt_q == CW'(1));

  // R10: a held operation keeps its remaining count
  p_hold_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start) |=> $stable(cnt_q));

endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  localparam int WORDS    = NUM_BLK * BLK_WORDS,
  localparam int IDX_W    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  op_kind_e          kind,
  input  logic [IDX_W-1:0]  op_idx,
  input  logic [DATA_W-1:0] op_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic              conflict
);
  localparam int BOFF  = $clog2(BLK_WORDS);
  localparam int BLK_W = IDX_W - BOFF;

  logic [DATA_W-1:0] mem [WORDS];
  logic [BLK_W-1:0]  op_blk;
  logic [DATA_W-1:0] tgt_word;

  assign op_blk = op_idx[IDX_W-1:BOFF];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam int BLK_OF = w / BLK_WORDS;
    logic              hit;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      case (kind)
        OP_PROG:  hit = (op_idx == IDX_W'(w));
        OP_BLOCK: hit = (op_blk == BLK_W'(BLK_OF));
        OP_CHIP:  hit = 1'b1;
        default:  hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (apply && hit)
        word_q <= (kind == OP_PROG) ? (word_q & op_data) : '1;
    end

    assign mem[w] = word_q;
  end

  assign rd_word  = mem[rd_idx];
  assign tgt_word = mem[op_idx];
  assign conflict = (kind == OP_PROG) && (|(~tgt_word & op_data));

  // R8: a program never raises a stored bit
  p_prog_clears_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && kind == OP_PROG) |=> ((tgt_word & ~$past(tgt_word)) == '0));

endmodule

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              op_done,
  input  logic              op_fail,
  output seq_state_e        st,
  output logic              start,
  output op_kind_e          op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  seq_state_e        st_q, st_n;
  logic              byp_q, byp_n;
  op_kind_e          kind_q, start_kind;
  logic [ADDR_W-1:0] oaddr_q;
  logic [DATA_W-1:0] odata_q;
  logic [7:0]        cmd;
  logic              hit_u1, hit_u2, hit_q;

  assign cmd    = wdata[7:0];
  assign hit_u1 = (addr == ADDR_W'(A_UNL1));
  assign hit_u2 = (addr == ADDR_W'(A_UNL2));
  assign hit_q  = (addr == ADDR_W'(A_QRY));

  always_comb begin
    st_n       = st_q;
    byp_n      = byp_q;
    start      = 1'b0;
    start_kind = OP_PROG;
    case (st_q)
      S_BUSY: begin
        if (op_done)
          st_n = op_fail ? S_FAIL : (byp_q ? S_BYP : S_READ);
        else if (wr_en && cmd == C_SUSP)
          st_n = S_SUSP;
      end
      S_SUSP: if (wr_en && cmd == C_RESUME) st_n = S_BUSY;
      S_FAIL, S_LOST: begin
        if (wr_en && cmd == C_RESET) begin
          st_n  = S_READ;
          byp_n = 1'b0;
        end
      end
      S_QRY: if (wr_en && cmd == C_RESET) st_n = S_READ;
      S_PGM, S_BYP_PGM: begin
        if (wr_en) begin
          start = 1'b1;
          st_n  = S_BUSY;
        end
      end
      default: begin
        if (wr_en) begin
          if (cmd == C_BAD) begin
            st_n = S_LOST;
          end else begin
            case (st_q)
              S_READ: begin
                if (hit_u1 && cmd == C_UNLK_A)     st_n = S_UNL1;
                else if (hit_q && cmd == C_QUERY)  st_n = S_QRY;
              end
              S_UNL1: st_n = (hit_u2 && cmd == C_UNLK_B) ? S_UNL2 : S_READ;
              S_UNL2: begin
                if (hit_u1 && cmd == C_PROG)        st_n = S_PGM;
                else if (hit_u1 && cmd == C_ERASE)  st_n = S_ERS1;
                else if (hit_u1 && cmd == C_BYPASS) begin
                  st_n  = S_BYP;
                  byp_n = 1'b1;
                end else                            st_n = S_READ;
              end
              S_ERS1: st_n = (hit_u1 && cmd == C_UNLK_A) ? S_ERS2 : S_READ;
              S_ERS2: st_n = (hit_u2 && cmd == C_UNLK_B) ? S_ERS3 : S_READ;
              S_ERS3: begin
                if (hit_u1 && cmd == C_CHIP) begin
                  start = 1'b1; start_kind = OP_CHIP;  st_n = S_BUSY;
                end else if (cmd == C_BLOCK) begin
                  start = 1'b1; start_kind = OP_BLOCK; st_n = S_BUSY;
                end else st_n = S_READ;
              end
              S_BYP: begin
                if (cmd == C_PROG)        st_n = S_BYP_PGM;
                else if (cmd == C_ERASE)  st_n = S_BYP_ERS;
                else if (cmd == C_BYP_X1) st_n = S_BYP_RST;
              end
              S_BYP_ERS: begin
                if (cmd == C_CHIP) begin
                  start = 1'b1; start_kind = OP_CHIP;  st_n = S_BUSY;
                end else if (cmd == C_BLOCK) begin
                  start = 1'b1; start_kind = OP_BLOCK; st_n = S_BUSY;
                end else st_n = S_BYP;
              end
              S_BYP_RST: begin
                if (cmd == C_BYP_X2) begin
                  st_n  = S_READ;
                  byp_n = 1'b0;
                end else st_n = S_BYP;
              end
              default: st_n = S_READ;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_READ;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      byp_q <= byp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= OP_PROG;
      oaddr_q <= '0;
      odata_q <= '0;
    end else if (start) begin
      kind_q  <= start_kind;
      oaddr_q <= addr;
      odata_q <= wdata;
    end
  end

  assign st      = st_q;
  assign op_kind = kind_q;
  assign op_addr = oaddr_q;
  assign op_data = odata_q;

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FAIL && !(wr_en && cmd == C_RESET)) |=> st_q == S_FAIL);

  p_bypass_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BYP && wr_en && cmd == C_RESET) |=> st_q == S_BYP);

  p_bad_opcode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd == C_BAD && st_q inside {S_READ, S_UNL1, S_UNL2, S_ERS1, S_ERS2,
      S_ERS3, S_BYP, S_BYP_ERS, S_BYP_RST}) |=> st_q == S_LOST);

  p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BUSY && !op_done && !(wr_en && cmd == C_SUSP)) |=> st_q == S_BUSY);

  p_suspend_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SUSP && !(wr_en && cmd == C_RESUME)) |=> (st_q == S_SUSP && $stable(oaddr_q)));

endmodule

// File: rtl/nor_cmd_core.sv
module nor_cmd_core
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int NUM_BLK   = 4,
  parameter int BLK_WORDS = 16,
  parameter int BUSY_CYC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              busy
);
  localparam int IDX_W = $clog2(NUM_BLK * BLK_WORDS);

  logic [1:0]        rs_q;
  logic              rst_core_n;
  seq_state_e        st;
  logic              start, op_done, op_fail, run;
  op_kind_e          op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data, rd_word, stat;
  logic              tog_q, tog_en, tog_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  nor_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .op_done(op_done), .op_fail(op_fail), .st(st), .start(start),
    .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data)
  );

  assign run = (st == S_BUSY);

  nor_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_core_n), .start(start), .run(run), .done(op_done)
  );

  nor_flash_array #(.DATA_W(DATA_W), .NUM_BLK(NUM_BLK), .BLK_WORDS(BLK_WORDS)) u_arr (
    .clk(clk), .rst_n(rst_core_n), .apply(op_done), .kind(op_kind),
    .op_idx(op_addr[IDX_W-1:0]), .op_data(op_data), .rd_idx(addr[IDX_W-1:0]),
    .rd_word(rd_word), .conflict(op_fail)
  );

  always_comb begin
    tog_en = 1'b0;
    tog_n  = tog_q;
    if (start) begin
      tog_en = 1'b1;
      tog_n  = 1'b0;
    end else if (rd_en && (st == S_BUSY || st == S_FAIL)) begin
      tog_en = 1'b1;
      tog_n  = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tog_q <= 1'b0;
    else if (tog_en) tog_q <= tog_n;
  end

  always_comb begin
    stat    = '0;
    stat[7] = (op_kind == OP_PROG) ? ~op_data[7] : 1'b0;
    stat[6] = tog_q;
    stat[5] = (st == S_FAIL);
  end

  always_comb begin
    case (st)
      S_BUSY, S_FAIL: rdata = stat;
      S_QRY:          rdata = DATA_W'(query_word(addr[7:0]));
      S_LOST:         rdata = '0;
      default:        rdata = rd_word;
    endcase
  end

  assign busy = run;

  // R9: status bits above bit 7 stay clear while busy
  p_status_upper_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    busy |-> (rdata[DATA_W-1:8] == '0 && rdata[5] == 1'b0));

endmodule

// File: tb/nor_cmd_core_test.sv
module nor_cmd_core_test;
  localparam int AW = 11, DW = 16, NB = 4, BW = 16, BC = 6;
  localparam int WORDS = NB * BW;

  localparam int M_READ = 0, M_U1 = 1, M_U2 = 2, M_PGM = 3, M_E1 = 4, M_E2 = 5,
                 M_E3 = 6, M_BYP = 7, M_BPGM = 8, M_BERS = 9, M_BRST = 10,
                 M_BUSY = 11, M_SUSP = 12, M_FAIL = 13, M_QRY = 14, M_LOST = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic busy;

  int tests = 0, fails = 0;
  string tag = "R1";

  logic [15:0] mm [WORDS];
  int md = M_READ, rem = 0, mkind = 0;
  bit mbyp = 1'b0, mtog = 1'b0;
  logic [10:0] maddr = '0;
  logic [15:0] mdata = '0;

  always #2 clk = ~clk;

  nor_cmd_core #(.ADDR_W(AW), .DATA_W(DW), .NUM_BLK(NB), .BLK_WORDS(BW), .BUSY_CYC(BC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  task automatic chk(input string t, input string what, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", t, what, got, exp);
    end
  endtask

  function automatic logic [15:0] mexp(input logic [10:0] a);
    logic [15:0] s;
    s = '0;
    s[7] = (mkind == 0) ? ~mdata[7] : 1'b0;
    s[6] = mtog;
    case (md)
      M_BUSY: return s;
      M_FAIL: begin s[5] = 1'b1; return s; end
      M_QRY:  return (a[7:0] == 8'h10) ? 16'h0051 : (a[7:0] == 8'h11) ? 16'h0052 :
                     (a[7:0] == 8'h12) ? 16'h0059 : 16'h0000;
      M_LOST: return 16'h0000;
      default: return mm[a[5:0]];
    endcase
  endfunction

  task automatic mstart(input int k, input logic [10:0] a, input logic [15:0] d);
    mkind = k; maddr = a; mdata = d; rem = BC; md = M_BUSY; mtog = 1'b0;
  endtask

  task automatic mfinish();
    bit bad = 1'b0;
    if (mkind == 0) begin
      bad = |(~mm[maddr[5:0]] & mdata);
      mm[maddr[5:0]] = mm[maddr[5:0]] & mdata;
    end else begin
      for (int j = 0; j < WORDS; j++)
        if (mkind == 2 || (j / BW) == int'(maddr[5:4])) mm[j] = 16'hFFFF;
    end
    md = bad ? M_FAIL : (mbyp ? M_BYP : M_READ);
  endtask

  task automatic mupdate(input bit we, input bit re, input logic [10:0] a, input logic [15:0] d);
    logic [7:0] c = d[7:0];
    bit a1 = (a == 11'h555);
    bit a2 = (a == 11'h2AA);
    if (re && (md == M_BUSY || md == M_FAIL)) mtog = ~mtog;
    if (md == M_BUSY) begin
      if (rem == 1) mfinish();
      else begin
        rem--;
        if (we && c == 8'hB0) md = M_SUSP;
      end
    end else if (md == M_SUSP) begin
      if (we && c == 8'h30) md = M_BUSY;
    end else if (md == M_FAIL || md == M_LOST) begin
      if (we && c == 8'hF0) begin md = M_READ; mbyp = 1'b0; end
    end else if (md == M_QRY) begin
      if (we && c == 8'hF0) md = M_READ;
    end else if (md == M_PGM || md == M_BPGM) begin
      if (we) mstart(0, a, d);
    end else if (we) begin
      if (c == 8'hFF) md = M_LOST;
      else case (md)
        M_READ: if (a1 && c == 8'hAA) md = M_U1; else if (a == 11'h055 && c == 8'h98) md = M_QRY;
        M_U1:   md = (a2 && c == 8'h55) ? M_U2 : M_READ;
        M_U2:   if (a1 && c == 8'hA0) md = M_PGM;
                else if (a1 && c == 8'h80) md = M_E1;
                else if (a1 && c == 8'h20) begin md = M_BYP; mbyp = 1'b1; end
                else md = M_READ;
        M_E1:   md = (a1 && c == 8'hAA) ? M_E2 : M_READ;
        M_E2:   md = (a2 && c == 8'h55) ? M_E3 : M_READ;
        M_E3:   if (a1 && c == 8'h10) mstart(2, a, d);
                else if (c == 8'h30) mstart(1, a, d);
                else md = M_READ;
        M_BYP:  if (c == 8'hA0) md = M_BPGM;
                else if (c == 8'h80) md = M_BERS;
                else if (c == 8'h90) md = M_BRST;
        M_BERS: if (c == 8'h10) mstart(2, a, d);
                else if (c == 8'h30) mstart(1, a, d);
                else md = M_BYP;
        M_BRST: if (c == 8'h00) begin md = M_READ; mbyp = 1'b0; end else md = M_BYP;
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit we, input bit re, input logic [10:0] a, input logic [15:0] d,
                      input bit has_exp, input logic [15:0] exp);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    #1;
    if (has_exp) chk(tag, "directed read", rdata, exp);
    chk(tag, "model rdata", rdata, mexp(a));
    chk(tag, "model busy", {15'd0, busy}, {15'd0, md == M_BUSY});
    @(posedge clk);
    mupdate(we, re, a, d);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d); step(1, 0, a, d, 0, '0); endtask
  task automatic rdx(input logic [10:0] a, input logic [15:0] e); step(0, 1, a, '0, 1, e); endtask
  task automatic idle(); step(0, 0, '0, '0, 0, '0); endtask
  task automatic unlock(); wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0055); endtask
  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    unlock(); wr(11'h555, 16'h00A0); wr(a, d);
  endtask
  task automatic erase_pre(); unlock(); wr(11'h555, 16'h0080); unlock(); endtask
  task automatic wait_done(output int n);
    n = 0;
    while (busy && n < 50) begin idle(); n++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R1 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < WORDS; i++) mm[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    tag = "R1";
    rdx(11'h000, 16'hFFFF);
    chk("R1", "busy after reset", {15'd0, busy}, 16'd0);

    tag = "R2";
    prog(11'h003, 16'h1234);
    wait_done(n);
    chk("R2", "busy cycles", 16'(n), 16'(BC));
    rdx(11'h003, 16'h1234);

    tag = "R9";
    prog(11'h013, 16'hABCD);
    rdx(11'h013, 16'h0000);
    rdx(11'h013, 16'h0040);
    tag = "R12";
    wr(11'h555, 16'h00AA);
    wr(11'h005, 16'h0000);
    wait_done(n);
    rdx(11'h013, 16'hABCD);
    rdx(11'h005, 16'hFFFF);

    tag = "R8";
    prog(11'h003, 16'h00FF);
    wait_done(n);
    rdx(11'h003, 16'h0020);
    rdx(11'h003, 16'h0060);
    wr(11'h555, 16'h00AA);
    rdx(11'h003, 16'h0020);
    wr(11'h000, 16'h00F0);
    rdx(11'h003, 16'h0034);

    tag = "R3";
    erase_pre(); wr(11'h005, 16'h0030);
    rdx(11'h005, 16'h0000);
    wait_done(n);
    rdx(11'h003, 16'hFFFF);
    rdx(11'h013, 16'hABCD);
    erase_pre(); wr(11'h555, 16'h0010);
    wait_done(n);
    rdx(11'h013, 16'hFFFF);

    tag = "R4";
    unlock(); wr(11'h000, 16'h00A0);
    wr(11'h013, 16'h0000);
    idle();
    rdx(11'h013, 16'hFFFF);
    unlock(); wr(11'h000, 16'h00F0);
    wr(11'h555, 16'h00A0); wr(11'h013, 16'h0000);
    idle();
    rdx(11'h013, 16'hFFFF);

    tag = "R5";
    unlock(); wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00A0); wr(11'h020, 16'h5A5A);
    wait_done(n);
    rdx(11'h020, 16'h5A5A);
    tag = "R6";
    wr(11'h000, 16'h00F0);
    wr(11'h000, 16'h00A0); wr(11'h021, 16'h1111);
    wait_done(n);
    rdx(11'h021, 16'h1111);
    tag = "R5";
    wr(11'h000, 16'h0080); wr(11'h02F, 16'h0030);
    wait_done(n);
    rdx(11'h020, 16'hFFFF);
    rdx(11'h021, 16'hFFFF);
    wr(11'h000, 16'h00A0); wr(11'h013, 16'h00F0);
    wait_done(n);
    rdx(11'h013, 16'h00F0);
    tag = "R6";
    wr(11'h000, 16'h0090); wr(11'h000, 16'h0000);
    wr(11'h000, 16'h00A0); wr(11'h022, 16'h0000);
    idle();
    rdx(11'h022, 16'hFFFF);

    tag = "R7";
    wr(11'h555, 16'h00AA); wr(11'h000, 16'h00FF);
    rdx(11'h013, 16'h0000);
    prog(11'h013, 16'h0000);
    idle();
    wr(11'h000, 16'h00F0);
    rdx(11'h013, 16'h00F0);
    unlock(); wr(11'h555, 16'h0020);
    wr(11'h000, 16'h00FF); wr(11'h000, 16'h00F0);
    wr(11'h000, 16'h00A0); wr(11'h030, 16'h0000);
    idle();
    rdx(11'h030, 16'hFFFF);

    tag = "R10";
    erase_pre(); wr(11'h010, 16'h0030);
    idle();
    wr(11'h000, 16'h00B0);
    chk("R10", "busy in suspend", {15'd0, busy}, 16'd0);
    rdx(11'h013, 16'h00F0);
    wr(11'h555, 16'h00AA);
    idle();
    rdx(11'h013, 16'h00F0);
    wr(11'h000, 16'h0030);
    chk("R10", "busy after resume", {15'd0, busy}, 16'd1);
    wait_done(n);
    chk("R10", "remaining cycles", 16'(n), 16'(BC - 2));
    rdx(11'h013, 16'hFFFF);

    tag = "R11";
    wr(11'h055, 16'h0098);
    rdx(11'h010, 16'h0051);
    rdx(11'h011, 16'h0052);
    rdx(11'h012, 16'h0059);
    rdx(11'h000, 16'h0000);
    wr(11'h000, 16'h00F0);
    rdx(11'h010, 16'hFFFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule